// File: doc/BRIEF.md
# Triangle Down-Spread Profile Generator

This block produces the multiplication word for a fractional-N feedback divider, so that a 25 MHz reference is multiplied to a 100 MHz output with optional spread-spectrum modulation for EMI reduction. The word is unsigned fixed point with 4 integer bits and 24 fractional bits. Its unmodulated value is 4.0. When spreading is on, the word follows a symmetric triangle. It falls linearly from 4.0 to a trough set by the selected depth, then rises back to 4.0. The frequency therefore never exceeds nominal.

The block runs on the reference clock. A prescaler produces an update tick every `TICK_DIV` clocks, and each half of the triangle lasts `HALF_STEPS` ticks. The defaults (3 and 130) give a profile period of 780 reference clocks, about 32.05 kHz. The spread enable and the depth select are sampled only where one period hands over to the next, at a point where the word sits at 4.0. A one-cycle strobe marks the first cycle of each period.

Top module: `ssc_tri_gen`

## Requirements
- R1: While reset is asserted and directly after it, `mult_word` equals 4.0, which is 0x4000000 with 24 fractional bits, and `period_strb` is low. The first period after reset runs with spreading off.
- R2: `period_strb` is high for exactly one clock. Consecutive strobes, and reset release followed by the first strobe, are spaced 2·HALF_STEPS·TICK_DIV clocks apart.
- R3: In every cycle where `period_strb` is high, `mult_word` equals 4.0.
- R4: In a period with spreading on and depth select 1 (0.5 %), the lowest word equals NOM − HALF_STEPS·⌊⌊NOM·50/10000⌋/HALF_STEPS⌋, where NOM = 2^26.
- R5: In a period with spreading on and depth select 0 (0.35 %), the lowest word equals NOM − HALF_STEPS·⌊⌊NOM·35/10000⌋/HALF_STEPS⌋.
- R6: `mult_word` never exceeds 4.0, and the highest word in each period equals 4.0.
- R7: In a period with spreading off, `mult_word` holds 4.0 in every cycle.
- R8: Spread enable and depth select are used only as they stand at the clock edge that begins a period. Changing them inside a period leaves that period's profile unchanged.
- R9: The word changes only on update ticks, once every TICK_DIV clocks. It falls for the first HALF_STEPS ticks of a period and rises for the rest, so the trough is first reached HALF_STEPS·TICK_DIV clocks after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spread_en | input | 1 | 1 turns on triangle modulation from the next period onward |
| depth_sel | input | 1 | 1 selects 0.5 % down-spread, 0 selects 0.35 % |
| mult_word | output | 28 | Multiplication word, 4 integer and 24 fractional bits |
| period_strb | output | 1 | One-clock pulse in the first cycle of each profile period |

## Verification
A corrupted step, direction or latched depth appears at the ports as a wrong trough value. It can also appear as a peak that overshoots or undershoots 4.0 when the strobe fires, and that difference is visible within one period of 780 clocks. A fault in the prescaler or the phase counter moves the strobe or the trough time by whole ticks, so it shows up at the very next strobe. Settings that are sampled at the wrong moment give a period whose trough does not match the inputs held at its strobe. The stimulus deliberately scrambles those inputs in the middle of each period to expose this.

// File: rtl/ssc_tri_pkg.sv
package ssc_tri_pkg;

    localparam int INT_W  = 4;
    localparam int FRAC_W = 24;
    localparam int WORD_W = INT_W + FRAC_W;

    typedef logic [WORD_W-1:0] word_t;

    // 4.0 in the fixed-point format: 25 MHz in, 100 MHz out
    localparam word_t NOMINAL = word_t'(4) << FRAC_W;

    // Per-tick decrement for a depth given in units of 0.01 %
    function automatic word_t step_for(input int unsigned depth_bp,
                                       input int unsigned half_steps);
        logic [63:0] dev;
        dev = (64'(NOMINAL) * 64'(depth_bp)) / 64'd10000;
        return word_t'(dev / 64'(half_steps));
    endfunction

endpackage

// File: rtl/ssc_tick_gen.sv
module ssc_tick_gen #(
    parameter int TICK_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

    generate
        if (TICK_DIV > 1) begin : g_div
            typedef struct packed {
                logic [CNT_W-1:0] cnt;
            } tick_st_t;

            tick_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (st_q.cnt == CNT_LAST) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign tick = (st_q.cnt == CNT_LAST);

            // R9
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_every
            assign tick = rst_n;
        end
    endgenerate

endmodule

// File: rtl/ssc_phase_seq.sv
module ssc_phase_seq #(
    parameter int HALF_STEPS = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic down_half,
    output logic wrap,
    output logic strobe
);

    localparam int TOTAL_STEPS = 2 * HALF_STEPS;
    localparam int POS_W = $clog2(TOTAL_STEPS);
    localparam logic [POS_W-1:0] POS_HALF = POS_W'(HALF_STEPS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(TOTAL_STEPS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             strobe;
    } phase_st_t;

    phase_st_t st_d, st_q;

    assign wrap      = tick && (st_q.pos == POS_LAST);
    assign down_half = (st_q.pos < POS_HALF);
    assign strobe    = st_q.strobe;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = wrap;
        if (tick) begin
            if (st_q.pos == POS_LAST) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R9
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= POS_LAST);

endmodule

// File: rtl/ssc_ramp_acc.sv
module ssc_ramp_acc
    import ssc_tri_pkg::*;
#(
    parameter int HALF_STEPS = 130,
    parameter int DEEP_BP    = 50,
    parameter int SHALLOW_BP = 35
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  wrap,
    input  logic  down_half,
    input  logic  spread_en,
    input  logic  depth_sel,
    output word_t word
);

    localparam word_t DEEP_STEP     = step_for(DEEP_BP, HALF_STEPS);
    localparam word_t SHALLOW_STEP  = step_for(SHALLOW_BP, HALF_STEPS);
    localparam word_t DEEP_FLOOR    = NOMINAL - word_t'(HALF_STEPS) * DEEP_STEP;
    localparam word_t SHALLOW_FLOOR = NOMINAL - word_t'(HALF_STEPS) * SHALLOW_STEP;

    typedef struct packed {
        word_t word;
        logic  act_en;
        logic  act_deep;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    word_t    step_sel;

    assign step_sel = st_q.act_deep ? DEEP_STEP : SHALLOW_STEP;

    always_comb begin
        st_d = st_q;
        if (tick && st_q.act_en) begin
            if (down_half) begin
                st_d.word = st_q.word - step_sel;
            end else begin
                st_d.word = st_q.word + step_sel;
            end
        end
        if (wrap) begin
            st_d.act_en   = spread_en;
            st_d.act_deep = depth_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word     <= NOMINAL;
            st_q.act_en   <= 1'b0;
            st_q.act_deep <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;

    // R6
    word_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.word <= NOMINAL);

    // R4
    deep_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.word >= DEEP_FLOOR);

    // R5
    shallow_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.act_deep |-> st_q.word >= SHALLOW_FLOOR);

    // R7
    idle_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.act_en |-> st_q.word == NOMINAL);

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(st_q.act_en) && $stable(st_q.act_deep));

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.word));

endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
    import ssc_tri_pkg::*;
#(
    parameter int TICK_DIV   = 3,
    parameter int HALF_STEPS = 130,
    parameter int DEEP_BP    = 50,
    parameter int SHALLOW_BP = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spread_en,
    input  logic              depth_sel,
    output logic [WORD_W-1:0] mult_word,
    output logic              period_strb
);

    logic  tick;
    logic  down_half;
    logic  wrap;
    word_t word;

    ssc_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ssc_phase_seq #(
        .HALF_STEPS (HALF_STEPS)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .down_half (down_half),
        .wrap      (wrap),
        .strobe    (period_strb)
    );

    ssc_ramp_acc #(
        .HALF_STEPS (HALF_STEPS),
        .DEEP_BP    (DEEP_BP),
        .SHALLOW_BP (SHALLOW_BP)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wrap      (wrap),
        .down_half (down_half),
        .spread_en (spread_en),
        .depth_sel (depth_sel),
        .word      (word)
    );

    assign mult_word = word;

    // R3
    strobe_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_strb |-> mult_word == NOMINAL);

endmodule

// File: tb/ssc_tri_gen_bench.sv
`timescale 1ns/1ps
module ssc_tri_gen_bench;
    import ssc_tri_pkg::*;

    localparam int CLK_PERIOD = 40;
    localparam int TICK_DIV   = 3;
    localparam int HALF       = 130;
    localparam int PER        = 2 * HALF * TICK_DIV;
    localparam int NPER       = 12;
    localparam int WD_CYC     = 60000;
    localparam longint NOM    = longint'(1) << 26;

    logic  clk = 1'b0;
    logic  rst_n;
    logic  spread_en;
    logic  depth_sel;
    word_t mult_word;
    logic  period_strb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssc_tri_gen #(
        .TICK_DIV   (TICK_DIV),
        .HALF_STEPS (HALF)
    ) u_ssc_tri_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .spread_en   (spread_en),
        .depth_sel   (depth_sel),
        .mult_word   (mult_word),
        .period_strb (period_strb)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_trough(input bit en, input bit deep);
        longint step;
        if (!en) return NOM;
        step = (NOM * (deep ? 50 : 35) / 10000) / HALF;
        return NOM - step * HALF;
    endfunction

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int     len, first_min, nper;
        longint mn, mx;
        bit     cfg_en, cfg_deep, plan_en, plan_deep;
        string  tag;

        void'($urandom(32'd1357));
        rst_n = 1'b0; spread_en = 1'b0; depth_sel = 1'b0;
        repeat (4) @(negedge clk);
        check(mult_word == word_t'(NOM), "R1 reset word", mult_word, NOM);
        check(period_strb == 1'b0, "R1 reset strobe", period_strb, 0);

        rst_n = 1'b1;
        // junk during the first period: it must stay flat anyway (R1, R8)
        spread_en = 1'b1; depth_sel = 1'b0;
        len = 0; first_min = 0; nper = 0;
        mn = NOM; mx = NOM; cfg_en = 1'b0; cfg_deep = 1'b0;
        plan_en = 1'b1; plan_deep = 1'b1;

        while (nper < NPER) begin
            @(negedge clk);
            len++;
            if (period_strb) begin
                check(len == PER, "R2 period length", len, PER);
                check(mx == NOM, "R6 peak", mx, NOM);
                tag = !cfg_en ? "R7 flat word" : (cfg_deep ? "R4 deep trough" : "R5 shallow trough");
                check(mn == exp_trough(cfg_en, cfg_deep), tag, mn, exp_trough(cfg_en, cfg_deep));
                if (cfg_en)
                    check(first_min == HALF * TICK_DIV, "R9 trough timing", first_min, HALF * TICK_DIV);
                check(mult_word == word_t'(NOM), "R3 word at strobe", mult_word, NOM);
                // settings in force for the period that starts now (R8)
                cfg_en = spread_en; cfg_deep = depth_sel;
                len = 0; first_min = 0; mn = mult_word; mx = mult_word;
                nper++;
                case (nper)
                    1: begin plan_en = 1'b1; plan_deep = 1'b0; end
                    2: begin plan_en = 1'b0; plan_deep = 1'b1; end
                    3: begin plan_en = 1'b1; plan_deep = 1'b1; end
                    default: begin plan_en = 1'($urandom % 2); plan_deep = 1'($urandom % 2); end
                endcase
                // scramble mid-period: must not affect this period (R8)
                spread_en = ~cfg_en; depth_sel = 1'($urandom % 2);
            end else begin
                if (len == 400 + int'($urandom % 200)) begin
                    spread_en = plan_en; depth_sel = plan_deep;
                end
                if (len == 650) begin
                    spread_en = plan_en; depth_sel = plan_deep;
                end
                if (longint'(mult_word) < mn) begin
                    mn = mult_word; first_min = len;
                end
                if (longint'(mult_word) > mx) mx = mult_word;
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule